// File: doc/BRIEF.md
# Pixel Depth Reduction and Range Limiter

This block takes a stream of three-channel pixels with 16-bit unsigned normalized components and turns each one into a narrower output code. The output depth comes from a small coded mode input. After the depth reduction, each channel is limited to its own programmable window. Lane 0 carries R/Cr, lane 1 carries G/Y and lane 2 carries B/Cb. Colour conversion, gamma and blending happen in other blocks.

Both data interfaces use valid/ready. A pixel is transferred on a clock edge where valid and ready are both high. Once the output presents valid, it keeps valid and keeps its data unchanged until out_ready takes the pixel. The input applies back-pressure only when both internal stages are full and the output is stalled. When out_ready stays high, a pixel appears two cycles after it is accepted.

The mode is read when a pixel enters the first stage. The clamp limits are read when the pixel enters the second stage. Change these configuration inputs only while no pixel is in flight.

Top module: `px_depth_clamp`

## Requirements
- R1: When out_ready stays high, a pixel accepted on edge k is presented on out_data with out_valid high after edge k+2. The valid flag travels with its data.
- R2: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged. in_ready is low only when both stages hold a pixel and out_ready is low. No pixel is lost or duplicated.
- R3: depth_mode value 1 gives 6-bit codes, 2 gives 8 bits, 3 gives 9 bits, 4 gives 10 bits, 5 gives 11 bits and 6 gives 12 bits. Each code is right-aligned in its 12-bit lane, and the bits above the depth are zero.
- R4: depth_mode 0 (no reduction) and the reserved value 7 pass the upper 12 bits of each input component to the output, truncated.
- R5: For an N-bit depth the code is floor((x + 2^(15-N)) / 2^(16-N)), which rounds half up.
- R6: A rounded code that exceeds 2^N-1 saturates to 2^N-1.
- R7: After depth reduction, each lane c is clamped to its limits. The result is min when the code is below min, max when it is above max, and the code itself otherwise. Lane c of lim_max, lim_min and out_data sits at bits [12c+11:12c]. Lane c of in_data sits at bits [16c+15:16c].
- R8: If a lane's min limit is greater than its max limit, that lane outputs its max limit.
- R9: While rst_n is low, out_valid is low and in_ready is high. After reset no pixel is presented until one has been accepted.
- R10: The three lanes are independent. The limits of one lane never affect another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_mode | input | 3 | Coded output depth selector |
| lim_max | input | 36 | Per-lane upper clamp limits, 12 bits each |
| lim_min | input | 36 | Per-lane lower clamp limits, 12 bits each |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | 48 | Three 16-bit normalized components |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept a pixel |
| out_data | output | 36 | Three 12-bit reduced and clamped codes |

## Verification
The following are checked on every cycle:
- output hold under a stall;
- the two-cycle arrival once out_ready is seen;
- that a reduced code never sets bits above its selected depth;
- that each lane lands inside its window, or on its max limit when the window is inverted.

Only the bench's scenarios can show the exact rounding and saturation values, the pass-through truncation for modes 0 and 7, and the lane-by-lane independence of the limits. The same applies to ordering and loss-freedom across a long stalled stream, which the scoreboard checks against its own arithmetic model.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    DM_PASS = 3'd0,
    DM_6    = 3'd1,
    DM_8    = 3'd2,
    DM_9    = 3'd3,
    DM_10   = 3'd4,
    DM_11   = 3'd5,
    DM_12   = 3'd6,
    DM_RSVD = 3'd7
  } depth_mode_e;

  // Number of output bits for a mode; 0 means no reduction (pass-through).
  function automatic int mode_bits(input logic [2:0] m);
    case (m)
      3'd1:    return 6;
      3'd2:    return 8;
      3'd3:    return 9;
      3'd4:    return 10;
      3'd5:    return 11;
      3'd6:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pdc_round_unit.sv
module pdc_round_unit #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic [2:0]       mode,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  import pdc_pkg::*;

  localparam int NMODES = 8;

  logic [OUT_W-1:0] cand [NMODES];

  // Pass-through for mode 0 and the reserved code: upper bits, truncated.
  assign cand[0] = din[IN_W-1 -: OUT_W];
  assign cand[7] = din[IN_W-1 -: OUT_W];

  // One fixed-shift rounding path per depth; the mux picks one.
  for (genvar g = 1; g < NMODES - 1; g++) begin : g_depth
    localparam int          BITS = mode_bits(3'(g));
    localparam int          SH   = IN_W - BITS;
    localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (SH - 1);
    localparam logic [IN_W:0] MAXC = ((IN_W+1)'(1) << BITS) - (IN_W+1)'(1);

    logic [IN_W:0] sum;
    logic [IN_W:0] q;
    assign sum = {1'b0, din} + HALF;
    assign q   = sum >> SH;
    assign cand[g] = (q > MAXC) ? MAXC[OUT_W-1:0] : q[OUT_W-1:0];
  end

  assign dout = cand[mode];

endmodule

// File: rtl/pdc_clamp_unit.sv
module pdc_clamp_unit #(
  parameter int W = 12
) (
  input  logic [W-1:0] code,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] res
);
  logic [W-1:0] capped;

  always_comb begin
    capped = (code > hi) ? hi : code;
    if (lo > hi)          res = hi;       // inverted window: upper limit wins
    else if (capped < lo) res = lo;
    else                  res = capped;
  end

endmodule

// File: rtl/px_depth_clamp.sv
module px_depth_clamp #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12,
  parameter int NCH   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           depth_mode,
  input  logic [NCH*OUT_W-1:0] lim_max,
  input  logic [NCH*OUT_W-1:0] lim_min,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NCH*IN_W-1:0]  in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NCH*OUT_W-1:0] out_data
);
  import pdc_pkg::*;

  localparam int CODE_BITS = NCH * OUT_W;

  logic                 s1_valid, s2_valid;
  logic [CODE_BITS-1:0] s1_code, s2_data;
  logic [CODE_BITS-1:0] rnd_code, clamp_res;
  logic                 adv1, adv2, in_fire;

  assign adv2     = !s2_valid || out_ready;
  assign adv1     = !s1_valid || adv2;
  assign in_ready = adv1;
  assign in_fire  = in_valid && adv1;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    pdc_round_unit #(.IN_W(IN_W), .OUT_W(OUT_W)) u_round (
      .mode (depth_mode),
      .din  (in_data[c*IN_W +: IN_W]),
      .dout (rnd_code[c*OUT_W +: OUT_W])
    );

    pdc_clamp_unit #(.W(OUT_W)) u_clamp (
      .code (s1_code[c*OUT_W +: OUT_W]),
      .lo   (lim_min[c*OUT_W +: OUT_W]),
      .hi   (lim_max[c*OUT_W +: OUT_W]),
      .res  (clamp_res[c*OUT_W +: OUT_W])
    );

    // R7: proper window -> result lies inside it
    p_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && adv2 && lim_min[c*OUT_W +: OUT_W] <= lim_max[c*OUT_W +: OUT_W])
      |=> (out_data[c*OUT_W +: OUT_W] <= $past(lim_max[c*OUT_W +: OUT_W]) &&
           out_data[c*OUT_W +: OUT_W] >= $past(lim_min[c*OUT_W +: OUT_W])));

    // R8: inverted window -> upper limit
    p_inverted_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && adv2 && lim_min[c*OUT_W +: OUT_W] > lim_max[c*OUT_W +: OUT_W])
      |=> (out_data[c*OUT_W +: OUT_W] == $past(lim_max[c*OUT_W +: OUT_W])));

    // R3: reduced code has no bits set above the selected depth
    p_code_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fire && depth_mode >= 3'd1 && depth_mode <= 3'd6)
      |=> ((s1_code[c*OUT_W +: OUT_W] >> mode_bits($past(depth_mode))) == '0));
  end

  // Stage 1: depth reduction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_code  <= '0;
    end else if (adv1) begin
      s1_valid <= in_valid;
      if (in_valid) s1_code <= rnd_code;
    end
  end

  // Stage 2: per-lane clamp, output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_data  <= '0;
    end else if (adv2) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_data <= clamp_res;
    end
  end

  assign out_valid = s2_valid;
  assign out_data  = s2_data;

  // R2: stalled output holds valid and data
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1: an accepted pixel is presented once the output has been drained
  p_two_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire ##1 out_ready |=> out_valid);

  // R2: input is only refused when both stages are full and stalled
  p_refuse_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

endmodule

// File: tb/tb_px_depth_clamp.sv
module tb_px_depth_clamp;
  localparam int IN_W = 16, OUT_W = 12, NCH = 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [2:0]           depth_mode = 3'd0;
  logic [NCH*OUT_W-1:0] lim_max = '1;
  logic [NCH*OUT_W-1:0] lim_min = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [NCH*IN_W-1:0]  in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic [NCH*OUT_W-1:0] out_data;

  px_depth_clamp #(.IN_W(IN_W), .OUT_W(OUT_W), .NCH(NCH)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_en = 0, done = 0;
  logic [NCH*OUT_W-1:0] exp_q[$];
  string                tag_q[$];
  int                   acc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [OUT_W-1:0] model_code(input logic [15:0] x, input logic [2:0] m);
    int bits, sh, r, mx;
    case (m)
      3'd1: bits = 6;  3'd2: bits = 8;  3'd3: bits = 9;
      3'd4: bits = 10; 3'd5: bits = 11; 3'd6: bits = 12;
      default: bits = 0;
    endcase
    if (bits == 0) return OUT_W'(x >> 4);
    sh = 16 - bits;
    r  = (int'(x) >> sh) + ((int'(x) >> (sh - 1)) & 1);
    mx = (1 << bits) - 1;
    if (r > mx) r = mx;
    return OUT_W'(r);
  endfunction

  function automatic logic [OUT_W-1:0] model_lim(input logic [OUT_W-1:0] v, lo, hi);
    if (lo > hi) return hi;
    if (v > hi)  return hi;
    if (v < lo)  return lo;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic send(input logic [15:0] a, b, c, input string tag);
    logic [NCH*OUT_W-1:0] e;
    logic [15:0] xs [3];
    bit r;
    int cread;
    xs[0] = a; xs[1] = b; xs[2] = c;
    for (int k = 0; k < NCH; k++)
      e[k*OUT_W +: OUT_W] = model_lim(model_code(xs[k], depth_mode),
                                      lim_min[k*OUT_W +: OUT_W], lim_max[k*OUT_W +: OUT_W]);
    do begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = {c, b, a};
      #1;
      r = in_ready;
      cread = cyc;
      @(posedge clk);
    end while (!r);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc_q.push_back(cread);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor / scoreboard; also drives out_ready
  initial begin : monitor
    bit held = 0;
    logic [NCH*OUT_W-1:0] held_d = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (held) begin
          check(out_valid && out_data == held_d, "R2", 64'(out_data), 64'(held_d));
          held = 0;
        end
        if (out_valid && !out_ready) begin
          held = 1;
          held_d = out_data;
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R2", 64'(out_data), 64'hX);
          end else begin
            logic [NCH*OUT_W-1:0] e;
            string t;
            int a;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = acc_q.pop_front();
            check(out_data == e, t, 64'(out_data), 64'(e));
            if (!bp_en) check(cyc - a == 2, "R1 latency", 64'(cyc - a), 64'd2);
          end
        end
      end
      @(posedge clk);
      #1;
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9 idle after reset", 64'(out_valid), 64'd0);

    // 8-bit rounding and saturation
    depth_mode = 3'd2;
    send(16'h0080, 16'h007F, 16'hFFFF, "R5 R6 mode2");
    send(16'h1234, 16'h8000, 16'h00FF, "R5 mode2");
    send(16'hFF7F, 16'hFF80, 16'h0000, "R6 mode2 edge");
    drain();

    // Other depths
    for (int m = 1; m <= 6; m++) begin
      depth_mode = 3'(m);
      send(16'hFFFF, 16'h7FFF, 16'h0400, "R3 depth sweep");
      send(16'h0200, 16'h01FF, 16'hABCD, "R3 R5 depth sweep");
      drain();
    end

    // Pass-through and reserved code
    depth_mode = 3'd0;
    send(16'hFFFF, 16'h123F, 16'h0008, "R4 mode0");
    drain();
    depth_mode = 3'd7;
    send(16'hABCD, 16'h000F, 16'h8001, "R4 mode7");
    drain();

    // Independent per-lane windows
    depth_mode = 3'd6;
    lim_max = {12'hC00, 12'h800, 12'h400};
    lim_min = {12'h900, 12'h100, 12'h010};
    send(16'h0000, 16'h0000, 16'h0000, "R7 R10 below");
    send(16'hFFFF, 16'hFFFF, 16'hFFFF, "R7 R10 above");
    send(16'h2000, 16'h4000, 16'hA000, "R7 R10 inside");
    drain();

    // Inverted window on lane 1
    lim_max = {12'hFFF, 12'h050, 12'hFFF};
    lim_min = {12'h000, 12'h300, 12'h000};
    send(16'h0000, 16'h8000, 16'hFFFF, "R8 inverted");
    send(16'h1111, 16'h0010, 16'h2222, "R8 inverted");
    drain();

    // Back-pressure stream
    lim_max = '1;
    lim_min = '0;
    depth_mode = 3'd4;
    bp_en = 1;
    for (int i = 0; i < 40; i++)
      send(16'(i * 1637), 16'(i * 911 + 7), 16'(65535 - i * 1301), "R2 stream");
    drain();
    bp_en = 0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 all delivered", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule